// File: doc/BRIEF.md
# Multi-Context Branch Direction Predictor with Forkable Return Stacks

This block predicts conditional branch directions for a core that runs several hardware contexts at once. All contexts share one table of 2-bit saturating counters. Each context keeps a private global outcome history, which is folded into the table index by XOR with the branch address, and a private circular stack of return addresses for call/return prediction.

A context can fork a new one. When it does, the new context starts with an all-zero history, so its first predictions use the address alone. Once the new context has resolved as many branches as the history is long, it predicts with full history correlation. The new context also takes a complete copy of its parent's return stack, pointer included, in a single cycle, so returns reached through the parent's pending calls still predict correctly.

The direction prediction and the stack top are combinational reads for the context on the predict port. Updates, stack operations and forks take effect at the next rising clock edge.

Top module: `mtbp_top`

## Requirements
- R1: After reset every counter holds 1, every history is zero and every stack entry and stack pointer is zero. So every context predicts not-taken at every address, and `ras_top` reads 0.
- R2: The counter index is `pred_pc ^ history[pred_tid]`, with the history zero-extended to the index width when it is shorter. The prediction is taken exactly when the indexed counter is 2 or 3. The result appears in the same cycle as the inputs.
- R3: An update changes the counter indexed by `upd_pc ^ history[upd_tid]`, using the history as it was before that edge. Taken adds one up to a ceiling of 3. Not-taken subtracts one down to a floor of 0.
- R4: An update shifts its outcome into bit 0 of the updating context's history, moving the older bits up by one and dropping the oldest. No other context's history changes.
- R5: A fork clears the child's history. If the child is also updated in the same cycle, the clear wins, but the counter update still happens.
- R6: A fork with a parent different from the child copies every stack entry and the stack pointer of the parent into the child in one edge. The copy uses the parent's state from before that edge. It overrides any push or pop aimed at the child in the same cycle. A push or pop on the parent in that cycle still applies to the parent.
- R7: A push writes the address at the pointer and then advances the pointer. A pop moves the pointer back. `ras_top` always shows the entry just below the pointer for the context on `pred_tid`.
- R8: A push and a pop on the same context in the same cycle overwrite the current top entry and leave the pointer unchanged.
- R9: The stack pointer wraps modulo the depth. Pushing more than the depth overwrites the oldest entries, and later pops return the newest entries in LIFO order.
- R10: A fork whose parent equals its child clears that context's history and leaves its return stack unchanged.
- R11: The counter table is shared. Training by one context at an index changes the prediction of any other context whose address and history give the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_tid | input | TID_W | Context to predict for |
| pred_pc | input | IDX_W | Word-address bits of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| ras_top | output | ADDR_W | Top return address of context `pred_tid` |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_tid | input | TID_W | Context of the resolved branch |
| upd_pc | input | IDX_W | Word-address bits of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| call_push | input | 1 | Push a return address |
| call_tid | input | TID_W | Context for the push |
| call_addr | input | ADDR_W | Return address to push |
| ret_pop | input | 1 | Pop a return address |
| ret_tid | input | TID_W | Context for the pop |
| spawn_valid | input | 1 | Fork strobe |
| spawn_parent | input | TID_W | Forking context |
| spawn_child | input | TID_W | Newly created context |

## Verification
The assertions assume that context IDs are always below the context count and that inputs are stable at each rising edge. They place no limit on combining same-cycle updates, pushes, pops and forks. Each property therefore carries the override conditions of R5 and R6 in its antecedent. The stimulus is driven only at falling edges, and every tag is below four. The stimulus deliberately combines a child update with its own fork, a parent push with a fork, and a self-fork, and it adds a long pseudo-random mix confined to a 16-entry address range so that counters reach both saturation limits.

// File: rtl/mtbp_pkg.sv
package mtbp_pkg;
   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_RESET = 2'd1;

   function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
      else       nxt = (cur == 2'd0) ? cur : cur - 2'd1;
      return nxt;
   endfunction
endpackage

// File: rtl/mtbp_counter_table.sv
module mtbp_counter_table #(
   parameter int unsigned IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   import mtbp_pkg::*;

   localparam int unsigned ENTRIES = 1 << IDX_W;

   ctr_t tbl_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_RESET;
      end else if (wr_en) begin
         tbl_q[wr_idx] <= ctr_next(tbl_q[wr_idx], wr_taken);
      end
   end

   assign rd_taken = tbl_q[rd_idx][1];
endmodule

// File: rtl/mtbp_history_bank.sv
module mtbp_history_bank #(
   parameter int unsigned NUM_CTX = 4,
   parameter int unsigned HIST_W  = 10,
   parameter int unsigned TID_W   = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             shift_en,
   input  logic [TID_W-1:0]                 shift_tid,
   input  logic                             shift_bit,
   input  logic                             clr_en,
   input  logic [TID_W-1:0]                 clr_tid,
   output logic [NUM_CTX-1:0][HIST_W-1:0]   hist_all
);
   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      logic [HIST_W-1:0] h_q;
      logic              clr_here;
      logic              shift_here;

      assign clr_here   = clr_en   && (clr_tid   == TID_W'(c));
      assign shift_here = shift_en && (shift_tid == TID_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          h_q <= '0;
         else if (clr_here)   h_q <= '0;
         else if (shift_here) h_q <= {h_q[HIST_W-2:0], shift_bit};
      end

      assign hist_all[c] = h_q;
   end
endmodule

// File: rtl/mtbp_return_stacks.sv
module mtbp_return_stacks #(
   parameter int unsigned NUM_CTX = 4,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned TID_W   = 2,
   parameter int unsigned PTR_W   = 3
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     push_en,
   input  logic [TID_W-1:0]                         push_tid,
   input  logic [ADDR_W-1:0]                        push_addr,
   input  logic                                     pop_en,
   input  logic [TID_W-1:0]                         pop_tid,
   input  logic                                     cp_en,
   input  logic [TID_W-1:0]                         cp_src,
   input  logic [TID_W-1:0]                         cp_dst,
   input  logic [TID_W-1:0]                         rd_tid,
   output logic [ADDR_W-1:0]                        rd_addr,
   output logic [NUM_CTX-1:0][PTR_W-1:0]            ptr_all
);
   logic [NUM_CTX-1:0][DEPTH-1:0][ADDR_W-1:0] stk_all;
   logic [PTR_W-1:0]                          rd_ptr;

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      logic [ADDR_W-1:0] ent_q [DEPTH];
      logic [PTR_W-1:0]  ptr_q;
      logic              cp_here;
      logic              push_here;
      logic              pop_here;

      assign cp_here   = cp_en   && (cp_dst   == TID_W'(c));
      assign push_here = push_en && (push_tid == TID_W'(c));
      assign pop_here  = pop_en  && (pop_tid  == TID_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            ptr_q <= '0;
         end else if (cp_here) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= stk_all[cp_src][i];
            ptr_q <= ptr_all[cp_src];
         end else if (push_here && pop_here) begin
            ent_q[ptr_q - 1'b1] <= push_addr;
         end else if (push_here) begin
            ent_q[ptr_q] <= push_addr;
            ptr_q        <= ptr_q + 1'b1;
         end else if (pop_here) begin
            ptr_q <= ptr_q - 1'b1;
         end
      end

      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         assign stk_all[c][e] = ent_q[e];
      end
      assign ptr_all[c] = ptr_q;
   end

   assign rd_ptr  = ptr_all[rd_tid] - 1'b1;
   assign rd_addr = stk_all[rd_tid][rd_ptr];
endmodule

// File: rtl/mtbp_top.sv
module mtbp_top #(
   parameter int unsigned NUM_CTX   = 4,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned HIST_W    = 10,
   parameter int unsigned RS_DEPTH  = 8,
   parameter int unsigned ADDR_W    = 32,
   parameter bit          HIST_HIGH = 1'b0,
   localparam int unsigned TID_W    = $clog2(NUM_CTX),
   localparam int unsigned PTR_W    = $clog2(RS_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TID_W-1:0]  pred_tid,
   input  logic [IDX_W-1:0]  pred_pc,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] ras_top,
   input  logic              upd_valid,
   input  logic [TID_W-1:0]  upd_tid,
   input  logic [IDX_W-1:0]  upd_pc,
   input  logic              upd_taken,
   input  logic              call_push,
   input  logic [TID_W-1:0]  call_tid,
   input  logic [ADDR_W-1:0] call_addr,
   input  logic              ret_pop,
   input  logic [TID_W-1:0]  ret_tid,
   input  logic              spawn_valid,
   input  logic [TID_W-1:0]  spawn_parent,
   input  logic [TID_W-1:0]  spawn_child
);
   initial begin : p_param_check
      if (NUM_CTX < 2)                  $fatal(1, "mtbp_top: NUM_CTX must be at least 2");
      if (HIST_W < 2 || HIST_W > IDX_W) $fatal(1, "mtbp_top: HIST_W must lie in 2..IDX_W");
      if (RS_DEPTH < 2 || (RS_DEPTH & (RS_DEPTH - 1)) != 0)
                                        $fatal(1, "mtbp_top: RS_DEPTH must be a power of two >= 2");
   end

   logic [NUM_CTX-1:0][HIST_W-1:0] hist_all;
   logic [NUM_CTX-1:0][PTR_W-1:0]  rs_ptr_all;
   logic [HIST_W-1:0]              pred_hist;
   logic [HIST_W-1:0]              upd_hist;
   logic [IDX_W-1:0]               pred_hx;
   logic [IDX_W-1:0]               upd_hx;
   logic [IDX_W-1:0]               pred_idx;
   logic [IDX_W-1:0]               upd_idx;
   logic                           rs_copy;

   assign pred_hist = hist_all[pred_tid];
   assign upd_hist  = hist_all[upd_tid];

   if (HIST_W == IDX_W) begin : g_hist_full
      assign pred_hx = pred_hist;
      assign upd_hx  = upd_hist;
   end else if (HIST_HIGH) begin : g_hist_high
      assign pred_hx = {pred_hist, {(IDX_W-HIST_W){1'b0}}};
      assign upd_hx  = {upd_hist,  {(IDX_W-HIST_W){1'b0}}};
   end else begin : g_hist_low
      assign pred_hx = {{(IDX_W-HIST_W){1'b0}}, pred_hist};
      assign upd_hx  = {{(IDX_W-HIST_W){1'b0}}, upd_hist};
   end

   assign pred_idx = pred_pc ^ pred_hx;
   assign upd_idx  = upd_pc  ^ upd_hx;
   assign rs_copy  = spawn_valid && (spawn_parent != spawn_child);

   mtbp_counter_table #(.IDX_W(IDX_W)) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (pred_idx),
      .rd_taken (pred_taken),
      .wr_en    (upd_valid),
      .wr_idx   (upd_idx),
      .wr_taken (upd_taken)
   );

   mtbp_history_bank #(.NUM_CTX(NUM_CTX), .HIST_W(HIST_W), .TID_W(TID_W)) i_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (upd_valid),
      .shift_tid (upd_tid),
      .shift_bit (upd_taken),
      .clr_en    (spawn_valid),
      .clr_tid   (spawn_child),
      .hist_all  (hist_all)
   );

   mtbp_return_stacks #(
      .NUM_CTX(NUM_CTX), .DEPTH(RS_DEPTH), .ADDR_W(ADDR_W), .TID_W(TID_W), .PTR_W(PTR_W)
   ) i_ras (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (call_push),
      .push_tid  (call_tid),
      .push_addr (call_addr),
      .pop_en    (ret_pop),
      .pop_tid   (ret_tid),
      .cp_en     (rs_copy),
      .cp_src    (spawn_parent),
      .cp_dst    (spawn_child),
      .rd_tid    (pred_tid),
      .rd_addr   (ras_top),
      .ptr_all   (rs_ptr_all)
   );
endmodule

// File: rtl/mtbp_checker.sv
module mtbp_checker #(
   parameter int unsigned NUM_CTX = 4,
   parameter int unsigned HIST_W  = 10,
   parameter int unsigned TID_W   = 2,
   parameter int unsigned PTR_W   = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           upd_valid,
   input logic [TID_W-1:0]               upd_tid,
   input logic                           upd_taken,
   input logic                           call_push,
   input logic [TID_W-1:0]               call_tid,
   input logic                           ret_pop,
   input logic [TID_W-1:0]               ret_tid,
   input logic                           spawn_valid,
   input logic [TID_W-1:0]               spawn_parent,
   input logic [TID_W-1:0]               spawn_child,
   input logic [NUM_CTX-1:0][HIST_W-1:0] hist_all,
   input logic [NUM_CTX-1:0][PTR_W-1:0]  ptr_all
);
   logic [TID_W-1:0]  child_q, upd_q, push_q;
   logic [HIST_W-1:0] hist_child_q, hist_upd_q;
   logic [PTR_W-1:0]  ptr_child_q, ptr_push_q, ptr_parent_now, ptr_push_inc;
   logic              plain_push, plain_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         child_q <= '0;
         upd_q   <= '0;
         push_q  <= '0;
      end else begin
         child_q <= spawn_child;
         upd_q   <= upd_tid;
         push_q  <= call_tid;
      end
   end

   assign hist_child_q   = hist_all[child_q];
   assign hist_upd_q     = hist_all[upd_q];
   assign ptr_child_q    = ptr_all[child_q];
   assign ptr_push_q     = ptr_all[push_q];
   assign ptr_parent_now = ptr_all[spawn_parent];
   assign ptr_push_inc   = ptr_all[call_tid] + 1'b1;
   assign plain_upd      = upd_valid && !(spawn_valid && spawn_child == upd_tid);
   assign plain_push     = call_push && !(ret_pop && ret_tid == call_tid)
                           && !(spawn_valid && spawn_child == call_tid && spawn_parent != call_tid);

   a_r5_child_hist_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      spawn_valid |=> hist_child_q == '0);

   a_r4_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
      plain_upd |=> hist_upd_q[0] == $past(upd_taken));

   a_r4_quiet_history: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_valid && !spawn_valid) |=> $stable(hist_all));

   a_r6_pointer_copied: assert property (@(posedge clk) disable iff (!rst_n)
      (spawn_valid && spawn_parent != spawn_child) |=> ptr_child_q == $past(ptr_parent_now));

   a_r7_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
      plain_push |=> ptr_push_q == $past(ptr_push_inc));
endmodule

bind mtbp_top mtbp_checker #(
   .NUM_CTX(NUM_CTX), .HIST_W(HIST_W), .TID_W(TID_W), .PTR_W(PTR_W)
) i_mtbp_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .upd_valid    (upd_valid),
   .upd_tid      (upd_tid),
   .upd_taken    (upd_taken),
   .call_push    (call_push),
   .call_tid     (call_tid),
   .ret_pop      (ret_pop),
   .ret_tid      (ret_tid),
   .spawn_valid  (spawn_valid),
   .spawn_parent (spawn_parent),
   .spawn_child  (spawn_child),
   .hist_all     (hist_all),
   .ptr_all      (rs_ptr_all)
);

// File: tb/test_mtbp_top.sv
module test_mtbp_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  pred_tid;
   logic [9:0]  pred_pc;
   logic        pred_taken;
   logic [31:0] ras_top;
   logic        upd_valid;
   logic [1:0]  upd_tid;
   logic [9:0]  upd_pc;
   logic        upd_taken;
   logic        call_push;
   logic [1:0]  call_tid;
   logic [31:0] call_addr;
   logic        ret_pop;
   logic [1:0]  ret_tid;
   logic        spawn_valid;
   logic [1:0]  spawn_parent;
   logic [1:0]  spawn_child;

   int n_cmp = 0;
   int n_bad = 0;

   int tbl [1024];
   int hist [4];
   int stk [4][8];
   int sp [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   mtbp_top i_mtbp_top (.*);

   function automatic int midx(int pc, int t);
      return (pc & 1023) ^ hist[t];
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic look(int t, int pc, string req);
      int et, ea;
      pred_tid = 2'(t);
      pred_pc  = 10'(pc);
      #1;
      et = (tbl[midx(pc, t)] >= 2) ? 1 : 0;
      ea = stk[t][(sp[t] + 7) % 8];
      chk(int'(pred_taken) == et, {req, " direction"}, int'(pred_taken), et);
      chk(int'(ras_top) == ea, {req, " stack top"}, int'(ras_top), ea);
   endtask

   task automatic idle_inputs();
      upd_valid = 0; upd_tid = 0; upd_pc = 0; upd_taken = 0;
      call_push = 0; call_tid = 0; call_addr = 0;
      ret_pop = 0; ret_tid = 0;
      spawn_valid = 0; spawn_parent = 0; spawn_child = 0;
   endtask

   task automatic tick();
      int nh [4];
      int ns [4][8];
      int np [4];
      nh = hist; ns = stk; np = sp;
      if (upd_valid) begin
         int i;
         i = midx(int'(upd_pc), int'(upd_tid));
         if (upd_taken) tbl[i] = (tbl[i] == 3) ? 3 : tbl[i] + 1;
         else           tbl[i] = (tbl[i] == 0) ? 0 : tbl[i] - 1;
         nh[upd_tid] = ((hist[upd_tid] << 1) | int'(upd_taken)) & 1023;
      end
      if (spawn_valid) nh[spawn_child] = 0;
      for (int c = 0; c < 4; c++) begin
         bit p, q;
         p = call_push && int'(call_tid) == c;
         q = ret_pop && int'(ret_tid) == c;
         if (spawn_valid && int'(spawn_child) == c && spawn_parent != spawn_child) begin
            ns[c] = stk[spawn_parent];
            np[c] = sp[spawn_parent];
         end else if (p && q) begin
            ns[c][(sp[c] + 7) % 8] = int'(call_addr);
         end else if (p) begin
            ns[c][sp[c]] = int'(call_addr);
            np[c] = (sp[c] + 1) % 8;
         end else if (q) begin
            np[c] = (sp[c] + 7) % 8;
         end
      end
      hist = nh; stk = ns; sp = np;
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic upd(int t, int pc, bit tk);
      upd_valid = 1; upd_tid = 2'(t); upd_pc = 10'(pc); upd_taken = tk;
   endtask

   task automatic push(int t, int a);
      call_push = 1; call_tid = 2'(t); call_addr = 32'(a);
   endtask

   task automatic pop(int t);
      ret_pop = 1; ret_tid = 2'(t);
   endtask

   task automatic fork_ctx(int par, int ch);
      spawn_valid = 1; spawn_parent = 2'(par); spawn_child = 2'(ch);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin : p_watchdog
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: run exceeded its cycle limit");
      summary();
      $finish;
   end

   initial begin : p_main
      logic [31:0] r;
      for (int i = 0; i < 1024; i++) tbl[i] = 1;
      for (int c = 0; c < 4; c++) begin
         hist[c] = 0; sp[c] = 0;
         for (int e = 0; e < 8; e++) stk[c][e] = 0;
      end
      rst_n = 0; pred_tid = 0; pred_pc = 0;
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state over every context and several addresses
      for (int t = 0; t < 4; t++) begin
         look(t, 0, "R1"); look(t, 16, "R1"); look(t, 1023, "R1");
      end

      // R3 / R5: train one index repeatedly, clearing child history each time
      for (int k = 0; k < 5; k++) begin
         upd(1, 16, 1); fork_ctx(0, 1); tick();
         look(1, 16, "R3"); look(1, 0, "R5");
      end
      // R11: another context with zero history sees the trained counter
      look(0, 16, "R11"); look(3, 16, "R11");
      for (int k = 0; k < 5; k++) begin
         upd(1, 16, 0); fork_ctx(0, 1); tick();
         look(1, 16, "R3");
      end
      upd(1, 16, 1); fork_ctx(0, 1); tick(); look(1, 16, "R3");

      // R2 / R4: history shifting on context 2 only
      for (int k = 0; k < 12; k++) begin
         upd(2, 256 + k, (k % 3) != 0); tick();
         look(2, 256 + k, "R2"); look(2, 5, "R2"); look(3, 256 + k, "R4");
      end

      // R5: update and fork of the same child in one cycle
      upd(2, 40, 1); fork_ctx(3, 2); tick();
      look(2, 40, "R5"); look(2, 7, "R5");

      // R7: push/pop order on context 0
      for (int k = 0; k < 3; k++) begin
         push(0, 'h1000 + 4 * k); tick(); look(0, 0, "R7");
      end
      for (int k = 0; k < 3; k++) begin
         pop(0); tick(); look(0, 0, "R7");
      end

      // R8: simultaneous push and pop replace the top
      push(0, 'h2000); tick();
      push(0, 'h2222); pop(0); tick(); look(0, 0, "R8");
      pop(0); tick(); look(0, 0, "R8");

      // R9: overflow wraps and keeps the newest entries
      for (int k = 0; k < 10; k++) begin
         push(3, 'h3000 + k); tick(); look(3, 0, "R9");
      end
      for (int k = 0; k < 10; k++) begin
         pop(3); tick(); look(3, 0, "R9");
      end

      // R6: fork copies parent stack; parent push applies to parent, child pop ignored
      push(0, 'h4000); tick();
      push(0, 'h4004); tick();
      fork_ctx(0, 2); push(0, 'h4008); pop(2); tick();
      look(2, 0, "R6"); look(0, 0, "R6");
      pop(2); tick(); look(2, 0, "R6");
      pop(2); tick(); look(2, 0, "R6"); look(0, 0, "R6");

      // R10: self-fork clears history but keeps the stack
      push(1, 'h5000); upd(1, 77, 1); tick();
      upd(1, 77, 1); tick();
      fork_ctx(1, 1); tick();
      look(1, 77, "R10"); look(1, 3, "R10");

      // Mixed pseudo-random traffic over a narrow address range
      r = 32'h1ACE_B00C;
      for (int k = 0; k < 4000; k++) begin
         r = {r[30:0], 1'b0} ^ (r[31] ? 32'h04C1_1DB7 : 32'h0);
         if (r[0])        upd(int'(r[2:1]), int'(r[6:3]), r[7]);
         if (r[10:8] == 0) fork_ctx(int'(r[12:11]), int'(r[14:13]));
         if (r[15])       push(int'(r[17:16]), int'(r[27:18]));
         if (r[28])       pop(int'(r[30:29]));
         tick();
         look(int'(r[9:8]), int'(r[6:3]), "R11");
         look(int'(r[31:30]), int'(r[27:24]), "R2");
      end

      summary();
      $finish;
   end
endmodule